// File: doc/BRIEF.md
# Timed Overcurrent Latch-Off Controller

This block is the digital sequencing for a two-channel protected load switch. Every channel watches its own enable pin and a current-regulation flag from an analog comparator. All channels also share a supply-good flag from an undervoltage detector. From these the block decides when the channel's power switch is commanded on. It also decides when the output gets a controlled slow ramp-down, when it gets a fast pull-down, and when the output is clamped low. An active-low fault line is modeled as a pull-low enable.

When a channel enters current regulation, it is allowed to stay there for a fixed interval so that short transients ride through. If regulation is still active when the interval expires, the switch is shut off and the fault is latched. Only deasserting enable clears the fault. After every turn-on, a blanking interval of the same length suppresses faults while the load's inrush settles. The interval length comes from a clock-frequency parameter and a millisecond parameter. An undervoltage condition forces every channel off and releases every fault.

Top module: `oc_latchoff_ctrl`

## Requirements
- R1: After reset, every channel has the switch command low, the output clamp high, the fault pull low, and both ramp-off pulses low.
- R2: The enable pins are active high when EN_HIGH=1 and active low when EN_HIGH=0. An enable edge at the pin changes the switch command at the third rising clock edge after it: two synchronizer stages plus one state register.
- R3: Let TRIP = (CLK_HZ/1000)*TRIP_MS cycles. A channel that is on and past blanking and that sees current regulation at its pin turns its switch off and asserts its fault pull at rising edge TRIP+3 after the regulation edge, provided regulation is held throughout.
- R4: If regulation drops before expiry, the channel stays on with no fault. A later regulation episode is timed over a fresh, full TRIP interval.
- R5: A latched fault is removed only when the channel's enable is deasserted. It is removed at the third rising edge after the enable pin change.
- R6: While enable stays asserted after a latch-off, the fault pull stays continuously asserted and rises only once, even if regulation persists.
- R7: For TRIP cycles after turn-on, regulation raises no fault. If regulation is present when blanking ends, the channel latches off at that moment, which is rising edge TRIP+3 after the enable edge.
- R8: ramp_off and fast_off are one-cycle pulses. An enable-driven turn-off with regulation inactive gives ramp_off. An enable-driven turn-off with regulation active gives fast_off. A timer latch-off gives fast_off. The two pulses never coincide.
- R9: out_clamp is asserted exactly when the switch command is low.
- R10: When supply_ok goes low, by the third rising edge all channels have switch low, clamp high and fault released. When supply_ok returns, channels whose enable is held turn on again.
- R11: Timing, latch-off and fault on one channel leave the other channel's outputs unchanged.
- R12: If the synchronized enable deassertion and the timer expiry reach the channel state in the same cycle, the turn-off wins. No fault is raised and fast_off is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | NUM_CH | Per-channel enable, polarity set by EN_HIGH |
| oc_flag | input | NUM_CH | Per-channel current-regulation-active flag |
| supply_ok | input | 1 | Shared supply above lockout threshold |
| sw_on | output | NUM_CH | Switch-on command |
| ramp_off | output | NUM_CH | One-cycle request for a slow controlled ramp-down |
| fast_off | output | NUM_CH | One-cycle request for a fast output pull-down |
| out_clamp | output | NUM_CH | Active output-low clamp request |
| fault_pull | output | NUM_CH | Drive fault line low (0 = released, high-impedance) |

## Verification
Enable removal and timer expiry can land on the same state-register cycle, and the resulting priority decides whether a fault is ever seen. The bench starts a regulation episode. It then releases enable so that its synchronized value arrives exactly at the expiry edge, and expects no fault and a fast pull-down pulse. It repeats the sequence with the release one cycle later, and expects the fault to appear for exactly one cycle before being cleared. Blanking end coinciding with held regulation is judged the same way, by sampling the exact edge TRIP+3.

// File: rtl/ocl_pkg.sv
package ocl_pkg;

  typedef enum logic [2:0] {
    CH_OFF,
    CH_BLANK,
    CH_ON,
    CH_REG,
    CH_LATCH
  } ch_state_t;

  function automatic int unsigned trip_cycles(input int unsigned hz, input int unsigned ms);
    return (hz / 1000) * ms;
  endfunction

endpackage

// File: rtl/ocl_sync.sv
module ocl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ocl_timer.sv
module ocl_timer #(
  parameter int unsigned LIMIT = 1500000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic last
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && !last) cnt <= cnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt <= TOP); // R3

endmodule

// File: rtl/ocl_chan.sv
module ocl_chan
  import ocl_pkg::*;
#(
  parameter int unsigned LIMIT = 1500000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_s,
  input  logic oc_s,
  input  logic pok_s,
  output logic sw_q,
  output logic slow_q,
  output logic fast_q,
  output logic clamp_q,
  output logic flt_q
);

  ch_state_t st, nxt;
  logic tmr_clr, tmr_run, tmr_last;
  logic go_slow, go_fast, nxt_on;

  ocl_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .run (tmr_run),
    .last(tmr_last)
  );

  always_comb begin
    nxt     = st;
    tmr_clr = 1'b0;
    tmr_run = 1'b0;
    go_slow = 1'b0;
    go_fast = 1'b0;
    if (!pok_s) begin
      nxt = CH_OFF;
    end else begin
      unique case (st)
        CH_OFF: begin
          if (en_s) begin
            nxt     = CH_BLANK;
            tmr_clr = 1'b1;
          end
        end
        CH_BLANK: begin
          if (!en_s) begin
            nxt     = CH_OFF;
            go_slow = !oc_s;
            go_fast = oc_s;
          end else if (tmr_last) begin
            nxt     = oc_s ? CH_LATCH : CH_ON;
            go_fast = oc_s;
          end else begin
            tmr_run = 1'b1;
          end
        end
        CH_ON: begin
          if (!en_s) begin
            nxt     = CH_OFF;
            go_slow = !oc_s;
            go_fast = oc_s;
          end else if (oc_s) begin
            nxt     = CH_REG;
            tmr_clr = 1'b1;
          end
        end
        CH_REG: begin
          if (!en_s) begin
            nxt     = CH_OFF;
            go_slow = !oc_s;
            go_fast = oc_s;
          end else if (!oc_s) begin
            nxt = CH_ON;
          end else if (tmr_last) begin
            nxt     = CH_LATCH;
            go_fast = 1'b1;
          end else begin
            tmr_run = 1'b1;
          end
        end
        CH_LATCH: begin
          if (!en_s) nxt = CH_OFF;
        end
        default: nxt = CH_OFF;
      endcase
    end
  end

  assign nxt_on = (nxt == CH_BLANK) || (nxt == CH_ON) || (nxt == CH_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CH_OFF;
      sw_q    <= 1'b0;
      clamp_q <= 1'b1;
      flt_q   <= 1'b0;
      slow_q  <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      st      <= nxt;
      sw_q    <= nxt_on;
      clamp_q <= !nxt_on;
      flt_q   <= (nxt == CH_LATCH);
      slow_q  <= go_slow;
      fast_q  <= go_fast;
    end
  end

  AST_FLT_SW_EXCL: assert property (@(posedge clk) disable iff (rst) flt_q |-> !sw_q); // R3
  AST_FLT_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_q) |-> ($past(sw_q) && $past(oc_s))); // R3
  AST_FLT_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(flt_q) |-> ($past(!en_s) || $past(!pok_s))); // R5
  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == CH_BLANK) |-> !flt_q); // R7
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (slow_q || fast_q) |=> !(slow_q || fast_q)); // R8
  AST_CLAMP_OFF: assert property (@(posedge clk) disable iff (rst) clamp_q |-> !sw_q); // R9
  AST_UV_FORCE: assert property (@(posedge clk) disable iff (rst)
    !pok_s |=> (!sw_q && !flt_q && clamp_q)); // R10

endmodule

// File: rtl/oc_latchoff_ctrl.sv
module oc_latchoff_ctrl #(
  parameter int          NUM_CH  = 2,
  parameter int unsigned CLK_HZ  = 125000000,
  parameter int unsigned TRIP_MS = 12,
  parameter bit          EN_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] en_pin,
  input  logic [NUM_CH-1:0] oc_flag,
  input  logic              supply_ok,
  output logic [NUM_CH-1:0] sw_on,
  output logic [NUM_CH-1:0] ramp_off,
  output logic [NUM_CH-1:0] fast_off,
  output logic [NUM_CH-1:0] out_clamp,
  output logic [NUM_CH-1:0] fault_pull
);

  localparam int unsigned TRIP = ocl_pkg::trip_cycles(CLK_HZ, TRIP_MS);
  localparam int SW = 2 * NUM_CH + 1;

  logic [NUM_CH-1:0] en_lvl, en_s, oc_s;
  logic              pok_s;
  logic [SW-1:0]     raw, synced;

  generate
    if (EN_HIGH) begin : g_en_hi
      assign en_lvl = en_pin;
    end else begin : g_en_lo
      assign en_lvl = ~en_pin;
    end
  endgenerate

  assign raw = {supply_ok, oc_flag, en_lvl};

  ocl_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw),
    .q  (synced)
  );

  assign en_s  = synced[NUM_CH-1:0];
  assign oc_s  = synced[2*NUM_CH-1:NUM_CH];
  assign pok_s = synced[SW-1];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ocl_chan #(.LIMIT(TRIP)) u_ch (
        .clk    (clk),
        .rst    (rst),
        .en_s   (en_s[c]),
        .oc_s   (oc_s[c]),
        .pok_s  (pok_s),
        .sw_q   (sw_on[c]),
        .slow_q (ramp_off[c]),
        .fast_q (fast_off[c]),
        .clamp_q(out_clamp[c]),
        .flt_q  (fault_pull[c])
      );
    end
  endgenerate

endmodule

// File: tb/tb_oc_latchoff_ctrl.sv
module tb_oc_latchoff_ctrl;

  localparam int unsigned HZ   = 10000;
  localparam int unsigned MS   = 12;
  localparam int          TRIP = (HZ / 1000) * MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] en = 2'b00, oc = 2'b00;
  logic supply = 1'b1;
  logic [1:0] sw, rmp, fst, clp, flt;

  logic [1:0] en_lo = 2'b11;
  logic [1:0] sw_lo, rmp_lo, fst_lo, clp_lo, flt_lo;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  oc_latchoff_ctrl #(.NUM_CH(2), .CLK_HZ(HZ), .TRIP_MS(MS), .EN_HIGH(1'b1)) dut (
    .clk(clk), .rst(rst), .en_pin(en), .oc_flag(oc), .supply_ok(supply),
    .sw_on(sw), .ramp_off(rmp), .fast_off(fst), .out_clamp(clp), .fault_pull(flt)
  );

  oc_latchoff_ctrl #(.NUM_CH(2), .CLK_HZ(HZ), .TRIP_MS(MS), .EN_HIGH(1'b0)) dut_lo (
    .clk(clk), .rst(rst), .en_pin(en_lo), .oc_flag(2'b00), .supply_ok(1'b1),
    .sw_on(sw_lo), .ramp_off(rmp_lo), .fast_off(fst_lo), .out_clamp(clp_lo), .fault_pull(flt_lo)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1", "sw after reset", sw, 0);
    chk("R1", "clamp after reset", clp, 3);
    chk("R1", "fault after reset", flt, 0);
    chk("R1", "pulses after reset", {rmp, fst}, 0);
  endtask

  task automatic t_turn_on();
    en[1] = 1'b1;
    tick(TRIP + 5);
    chk("R11", "ch1 on alone", sw, 2'b10);
    en[0] = 1'b1;
    tick(2);
    chk("R2", "sw0 before third edge", sw[0], 0);
    tick(1);
    chk("R2", "sw0 at third edge", sw[0], 1);
    chk("R9", "clamp0 follows sw", clp[0], 0);
    tick(TRIP + 5);
  endtask

  task automatic t_timer_latch();
    int rises;
    logic prev;
    oc[0] = 1'b1;
    tick(50);
    oc[0] = 1'b0;
    tick(5);
    chk("R4", "sw0 after short regulation", sw[0], 1);
    chk("R4", "no fault after short regulation", flt[0], 0);
    oc[0] = 1'b1;
    tick(TRIP + 2);
    chk("R4", "fresh interval not yet expired", flt[0], 0);
    chk("R3", "sw0 still on before expiry", sw[0], 1);
    tick(1);
    chk("R3", "fault at TRIP+3", flt[0], 1);
    chk("R3", "sw0 off at latch", sw[0], 0);
    chk("R8", "fast pulse at latch", fst[0], 1);
    chk("R9", "clamp0 at latch", clp[0], 1);
    tick(1);
    chk("R8", "fast pulse one cycle", fst[0], 0);
    rises = 0;
    prev = flt[0];
    for (int i = 0; i < 200; i++) begin
      tick(1);
      if (flt[0] && !prev) rises++;
      if (!flt[0] || !sw[1]) break;
      prev = flt[0];
    end
    chk("R6", "fault held while enabled", flt[0], 1);
    chk("R6", "fault re-rises", rises, 0);
    chk("R11", "ch1 unaffected by ch0 latch", {sw[1], flt[1]}, 2'b10);
    en[0] = 1'b0;
    tick(2);
    chk("R5", "fault before enable seen", flt[0], 1);
    tick(1);
    chk("R5", "fault cleared by enable", flt[0], 0);
    oc[0] = 1'b0;
    tick(5);
  endtask

  task automatic t_blank();
    en[0] = 1'b1;
    oc[0] = 1'b1;
    tick(20);
    oc[0] = 1'b0;
    tick(TRIP + 10);
    chk("R7", "inrush blanked, sw on", sw[0], 1);
    chk("R7", "inrush blanked, no fault", flt[0], 0);
    en[0] = 1'b0;
    tick(5);
    en[0] = 1'b1;
    oc[0] = 1'b1;
    tick(TRIP + 2);
    chk("R7", "no fault inside blanking", flt[0], 0);
    tick(1);
    chk("R7", "latch at blanking end", flt[0], 1);
    en[0] = 1'b0;
    oc[0] = 1'b0;
    tick(5);
  endtask

  task automatic t_offs();
    en[0] = 1'b1;
    tick(TRIP + 8);
    en[0] = 1'b0;
    tick(2);
    chk("R8", "slow pulse not early", rmp[0], 0);
    tick(1);
    chk("R8", "slow pulse on enable off", {rmp[0], fst[0], sw[0]}, 3'b100);
    tick(1);
    chk("R8", "slow pulse one cycle", rmp[0], 0);
    en[0] = 1'b1;
    tick(TRIP + 8);
    oc[0] = 1'b1;
    tick(10);
    en[0] = 1'b0;
    tick(3);
    chk("R8", "fast pulse on enable off in regulation", {rmp[0], fst[0]}, 2'b01);
    oc[0] = 1'b0;
    tick(5);
  endtask

  task automatic t_race();
    en[0] = 1'b1;
    tick(TRIP + 8);
    oc[0] = 1'b1;
    tick(TRIP);
    en[0] = 1'b0;
    tick(2);
    chk("R12", "no fault before coincidence", flt[0], 0);
    tick(1);
    chk("R12", "enable wins at expiry", {flt[0], fst[0], sw[0]}, 3'b010);
    tick(3);
    chk("R12", "still no fault", flt[0], 0);
    oc[0] = 1'b0;
    en[0] = 1'b1;
    tick(TRIP + 8);
    oc[0] = 1'b1;
    tick(TRIP + 1);
    en[0] = 1'b0;
    tick(2);
    chk("R12", "expiry one cycle ahead latches", flt[0], 1);
    tick(1);
    chk("R12", "fault cleared next cycle", flt[0], 0);
    oc[0] = 1'b0;
    tick(5);
  endtask

  task automatic t_uv();
    en[0] = 1'b1;
    tick(TRIP + 8);
    oc[1] = 1'b1;
    tick(TRIP + 3);
    chk("R3", "ch1 latched", flt[1], 1);
    chk("R11", "ch0 unaffected by ch1 latch", {sw[0], flt[0]}, 2'b10);
    supply = 1'b0;
    tick(3);
    chk("R10", "all switches off in lockout", sw, 0);
    chk("R10", "faults released in lockout", flt, 0);
    chk("R10", "clamps in lockout", clp, 3);
    oc[1] = 1'b0;
    supply = 1'b1;
    tick(3);
    chk("R10", "channels resume after lockout", sw, 3);
  endtask

  task automatic t_polarity();
    chk("R2", "active-low variant off with pins high", sw_lo, 0);
    en_lo[0] = 1'b0;
    tick(3);
    chk("R2", "active-low variant on with pin low", sw_lo, 2'b01);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_polarity();
    t_turn_on();
    t_timer_latch();
    t_blank();
    t_offs();
    t_race();
    t_uv();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule